// File: doc/BRIEF.md
# Serial Shift-Chain Output Controller

This block drives a cascade of external serial-in, parallel-out shift registers from a small register bank on a 32-bit register bus. The chain is built from up to three 8-bit groups, so it provides 8, 16 or 24 parallel outputs. Each refresh serialises a frame onto a data pin and a shift clock, most significant bit first. A store pulse then latches all parallel outputs together.

Each bit of a frame comes from one of two places. By default it is the CPU data register. The low 14 bits can instead be handed to hardware status inputs through ownership masks: two bits to a modem-status input, and four 3-bit fields to four PHY status inputs. A refresh is started by software through a self-clearing request bit, or periodically by an internal rate timer at one of four rates. Register writes are single-cycle and accepted unconditionally. Reads are combinational from the address. The serial pins carry no back-pressure: the external registers are assumed to follow the shift clock.

Top module: `schain_ctrl`

## Requirements
- R1: The register map is control A at 0x00, control B at 0x04, data 0 at 0x08, data 1 at 0x0C and access at 0x10. After reset, all five read as zero.
- R2: Control B bits [2:0] enable groups 0 to 2. A refresh produces 8 × (index of the highest enabled group + 1) capture edges, so the frame is 8, 16 or 24 bits long.
- R3: Bits leave most significant first, and the data pin is steady for a whole bit period. After a refresh of length L, external output k (for k < L) holds frame bit k.
- R4: Writing 1 to control A bit 31 requests a refresh, and that bit reads 1 while the request is pending. It clears when the shift starts. A request made during a shift is held and served after that shift ends.
- R5: Control A bit 26 selects the capture edge. A value of 1 selects the falling edge with the shift clock idling high. A value of 0 selects the rising edge with the shift clock idling low. The capture edge falls in the middle of each bit period.
- R6: Control A bits [25:24] form an ownership mask. A set bit j (j = 0 or 1) makes frame bit j come from modem-status input bit j instead of data 0.
- R7: PHY ownership masks sit at control A [29:27], control B [5:3], control B [8:6] and control B [17:15]. Each one hands frame bits 2–4, 5–7, 8–10 or 11–13 respectively to the matching 3-bit slice of the PHY status input.
- R8: When control B bits [31:30] equal 2'b10, refreshes start every CLK_HZ/2, /4, /8 or /10 clock cycles. The divisor is chosen by control B bits [24:23] = 00, 01, 10 or 11. Any other value stops automatic refresh.
- R9: Reading data 0 returns the value last written by the CPU, never the hardware-owned values.
- R10: After the last bit, the store pin is high for exactly CLK_DIV clock cycles while the shift clock sits at its idle level.
- R11: Control A bit 0 reads 1 while a shift or store sequence is in progress and 0 otherwise.
- R12: With no group enabled, a request is consumed without any shift clock edge or store pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 5 | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| modem_stat | input | 2 | Modem status bits for frame bits 1:0 |
| phy_stat | input | 12 | Four 3-bit PHY status slices, PHY1 in bits 2:0 |
| sh_clk | output | 1 | Shift clock to the external chain |
| sh_data | output | 1 | Serial data to the external chain |
| sh_store | output | 1 | Store/latch pulse for the parallel outputs |

## Verification
The bench models the external chain at the pins. It captures on the configured edge and latches on the store pulse. It compares the latched outputs against frames built from random data, ownership masks and status inputs.

Several targeted cases cover specific faults:
- Frames with only the top group enabled catch a length computed from the number of enabled groups instead of the highest one: too few capture edges would be seen.
- Mixed edge settings catch data that changes on the capture edge, which would show up as shifted or corrupted bits.
- A second request issued mid-shift must yield exactly two store pulses with the second data. A dropped request gives one pulse, and an early restart corrupts the frame.
- Store-pulse spacing is measured in automatic mode at two rates, and the case with no group enabled must stay silent.

// File: rtl/schain_pkg.sv
package schain_pkg;
  localparam logic [4:0] ADDR_CTRL_A = 5'h00;
  localparam logic [4:0] ADDR_CTRL_B = 5'h04;
  localparam logic [4:0] ADDR_DATA0  = 5'h08;
  localparam logic [4:0] ADDR_DATA1  = 5'h0C;
  localparam logic [4:0] ADDR_ACCESS = 5'h10;

  // bits of control A that hold configuration (edge, modem mask, PHY1 mask)
  localparam logic [31:0] CTRL_A_KEEP = 32'h3F00_0000;

  localparam int MODEM_W = 2;
  localparam int PHY_W   = 3;
  localparam int N_PHY   = 4;
  localparam int HW_BITS = MODEM_W + N_PHY * PHY_W;

  typedef enum logic [1:0] {SH_IDLE, SH_SHIFT, SH_STORE} sh_state_t;
endpackage

// File: rtl/schain_regs.sv
module schain_regs
  import schain_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [4:0]  addr,
  input  logic [31:0] wdata,
  input  logic        busy,
  input  logic        pend,
  output logic [31:0] rdata,
  output logic [31:0] ctrl_a_q,
  output logic [31:0] ctrl_b_q,
  output logic [31:0] data0_q,
  output logic        sw_req
);
  logic [31:0] data1_q, access_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_a_q <= '0;
      ctrl_b_q <= '0;
      data0_q  <= '0;
      data1_q  <= '0;
      access_q <= '0;
    end else if (wr_en) begin
      case (addr)
        ADDR_CTRL_A: ctrl_a_q <= wdata & CTRL_A_KEEP;
        ADDR_CTRL_B: ctrl_b_q <= wdata;
        ADDR_DATA0:  data0_q  <= wdata;
        ADDR_DATA1:  data1_q  <= wdata;
        ADDR_ACCESS: access_q <= wdata;
        default: ;
      endcase
    end
  end

  assign sw_req = wr_en && (addr == ADDR_CTRL_A) && wdata[31];

  always_comb begin
    case (addr)
      ADDR_CTRL_A: rdata = {pend, ctrl_a_q[30:1], busy};
      ADDR_CTRL_B: rdata = ctrl_b_q;
      ADDR_DATA0:  rdata = data0_q;
      ADDR_DATA1:  rdata = data1_q;
      ADDR_ACCESS: rdata = access_q;
      default:     rdata = '0;
    endcase
  end

  // R9: a data-0 write is what the register holds on the next cycle
  assert_data0_keeps_cpu_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_DATA0) |=> (data0_q == $past(wdata)));
endmodule

// File: rtl/schain_rate_timer.sv
module schain_rate_timer #(
  parameter int CLK_HZ = 100_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       auto_en,
  input  logic [1:0] rate_sel,
  output logic       tick_o
);
  localparam int CNT_W = $clog2(CLK_HZ / 2 + 1);

  logic [CNT_W-1:0] cnt_q, period;

  always_comb begin
    case (rate_sel)
      2'b00:   period = CNT_W'(CLK_HZ / 2);
      2'b01:   period = CNT_W'(CLK_HZ / 4);
      2'b10:   period = CNT_W'(CLK_HZ / 8);
      default: period = CNT_W'(CLK_HZ / 10);
    endcase
  end

  assign tick_o = auto_en && (cnt_q >= period - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (!auto_en)    cnt_q <= '0;
    else if (tick_o)      cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end

  // R8: ticks are never back to back
  assert_tick_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);
endmodule

// File: rtl/schain_shifter.sv
module schain_shifter
  import schain_pkg::*;
#(
  parameter int CHAIN_W = 24,
  parameter int CLK_DIV = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic [CHAIN_W-1:0]           frame,
  input  logic [$clog2(CHAIN_W+1)-1:0] len,
  input  logic                         edge_fall,
  output logic                         busy,
  output logic                         sh_clk,
  output logic                         sh_data,
  output logic                         sh_store
);
  localparam int IDX_W = $clog2(CHAIN_W);
  localparam int PH_W  = $clog2(CLK_DIV);
  localparam int HALF  = CLK_DIV / 2;

  sh_state_t          state_q;
  logic [CHAIN_W-1:0] frame_q;
  logic [IDX_W-1:0]   idx_q;
  logic [PH_W-1:0]    phase_q;
  logic               last_phase;

  assign last_phase = (phase_q == PH_W'(CLK_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SH_IDLE;
      frame_q <= '0;
      idx_q   <= '0;
      phase_q <= '0;
    end else begin
      case (state_q)
        SH_IDLE: if (start && len != '0) begin
          frame_q <= frame;
          idx_q   <= IDX_W'(len - 1'b1);
          phase_q <= '0;
          state_q <= SH_SHIFT;
        end
        SH_SHIFT: begin
          phase_q <= last_phase ? '0 : phase_q + 1'b1;
          if (last_phase) begin
            if (idx_q == '0) state_q <= SH_STORE;
            else             idx_q   <= idx_q - 1'b1;
          end
        end
        SH_STORE: begin
          phase_q <= last_phase ? '0 : phase_q + 1'b1;
          if (last_phase) state_q <= SH_IDLE;
        end
        default: state_q <= SH_IDLE;
      endcase
    end
  end

  assign busy     = (state_q != SH_IDLE);
  assign sh_data  = (state_q == SH_SHIFT) && frame_q[idx_q];
  assign sh_store = (state_q == SH_STORE);
  assign sh_clk   = ((state_q == SH_SHIFT) && (phase_q >= PH_W'(HALF))) ^ edge_fall;

  // R5: the capture edge of the chosen polarity lands mid-bit
  assert_capture_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SH_SHIFT && phase_q == PH_W'(HALF) && $stable(edge_fall))
      |-> (sh_clk == !edge_fall) && ($past(sh_clk) == edge_fall));

  // R3: data does not move inside a bit period
  assert_data_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SH_SHIFT && phase_q != '0) |-> $stable(sh_data));

  // R10: store follows the final bit, clock parked at idle
  assert_store_after_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sh_store) |-> ($past(state_q) == SH_SHIFT) && ($past(idx_q) == '0));
  assert_store_clk_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sh_store |-> (sh_clk == edge_fall));

  // R11: an accepted start makes the block busy
  assert_busy_on_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && len != '0) |=> busy);
endmodule

// File: rtl/schain_ctrl.sv
module schain_ctrl
  import schain_pkg::*;
#(
  parameter int GROUP_W  = 8,
  parameter int N_GROUPS = 3,
  parameter int CLK_DIV  = 4,
  parameter int CLK_HZ   = 100_000_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr_en,
  input  logic [4:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic [1:0]  modem_stat,
  input  logic [11:0] phy_stat,
  output logic        sh_clk,
  output logic        sh_data,
  output logic        sh_store
);
  localparam int CHAIN_W = GROUP_W * N_GROUPS;
  localparam int LEN_W   = $clog2(CHAIN_W + 1);

  logic [31:0] ctrl_a_q, ctrl_b_q, data0_q;
  logic        sw_req, tick, busy, pend_q, new_req, start_go;
  logic [CHAIN_W-1:0] own_mask, hw_val, frame;
  logic [LEN_W-1:0]   len;
  logic [PHY_W-1:0]   phy_mask [N_PHY];

  schain_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
    .wdata(reg_wdata), .busy(busy), .pend(pend_q), .rdata(reg_rdata),
    .ctrl_a_q(ctrl_a_q), .ctrl_b_q(ctrl_b_q), .data0_q(data0_q), .sw_req(sw_req)
  );

  schain_rate_timer #(.CLK_HZ(CLK_HZ)) u_timer (
    .clk(clk), .rst_n(rst_n), .auto_en(ctrl_b_q[31:30] == 2'b10),
    .rate_sel(ctrl_b_q[24:23]), .tick_o(tick)
  );

  // ownership fields: positions are fixed by the register layout
  assign phy_mask[0] = ctrl_a_q[29:27];
  assign phy_mask[1] = ctrl_b_q[5:3];
  assign phy_mask[2] = ctrl_b_q[8:6];
  assign phy_mask[3] = ctrl_b_q[17:15];

  assign own_mask[MODEM_W-1:0] = ctrl_a_q[25:24];
  assign hw_val[MODEM_W-1:0]   = modem_stat;
  for (genvar p = 0; p < N_PHY; p++) begin : g_phy
    assign own_mask[MODEM_W + p*PHY_W +: PHY_W] = phy_mask[p];
    assign hw_val[MODEM_W + p*PHY_W +: PHY_W]   = phy_stat[p*PHY_W +: PHY_W];
  end
  assign own_mask[CHAIN_W-1:HW_BITS] = '0;
  assign hw_val[CHAIN_W-1:HW_BITS]   = '0;

  assign frame = (own_mask & hw_val) | (~own_mask & data0_q[CHAIN_W-1:0]);

  // chain length follows the highest enabled group
  always_comb begin
    len = '0;
    for (int g = 0; g < N_GROUPS; g++)
      if (ctrl_b_q[g]) len = LEN_W'((g + 1) * GROUP_W);
  end

  assign new_req  = sw_req | tick;
  assign start_go = pend_q && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= new_req | (pend_q & !start_go);
  end

  schain_shifter #(.CHAIN_W(CHAIN_W), .CLK_DIV(CLK_DIV)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(start_go), .frame(frame), .len(len),
    .edge_fall(ctrl_a_q[26]), .busy(busy), .sh_clk(sh_clk),
    .sh_data(sh_data), .sh_store(sh_store)
  );

  // R4: a request during a shift is kept until the shift ends
  assert_pend_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && busy) |=> pend_q);
  // R4: the pending flag drops once its shift is launched
  assert_pend_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start_go && !new_req) |=> !pend_q);
  // R12: no enabled group means no store pulse
  assert_no_groups_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ctrl_b_q[N_GROUPS-1:0] == '0) |=> !sh_store);
endmodule

// File: tb/tb_schain_ctrl.sv
module tb_schain_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [1:0]  modem_stat = '0;
  logic [11:0] phy_stat = '0;
  logic        sh_clk, sh_data, sh_store;

  schain_ctrl #(.CLK_DIV(4), .CLK_HZ(4000)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .modem_stat(modem_stat),
    .phy_stat(phy_stat), .sh_clk(sh_clk), .sh_data(sh_data), .sh_store(sh_store)
  );

  always #5 clk = ~clk;

  int total = 0, bad = 0, cyc = 0, edge_cnt = 0, store_cnt = 0, store_hi = 0;
  int last_t = 0, prev_t = 0;
  bit cfg_fall = 1'b0, done = 1'b0;
  logic [23:0] chain = '0, par_out = '0;

  // behavioural model of the external cascade
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (sh_store === 1'b1) store_hi <= store_hi + 1;
  end
  always @(sh_clk) begin
    if ((sh_clk === 1'b1 && !cfg_fall) || (sh_clk === 1'b0 && cfg_fall)) begin
      chain = {chain[22:0], sh_data};
      edge_cnt++;
    end
  end
  always @(posedge sh_store) begin
    par_out = chain;
    prev_t = last_t;
    last_t = cyc;
    store_cnt++;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int n = 0; n < 5000; n++) begin
      rd(5'h00, v);
      if (v[0] == 1'b0 && v[31] == 1'b0) break;
    end
  endtask

  function automatic int chain_len(logic [2:0] g);
    return g[2] ? 24 : g[1] ? 16 : g[0] ? 8 : 0;
  endfunction

  function automatic logic [23:0] expect_frame(logic [23:0] d, logic [1:0] mm,
      logic [11:0] pm, logic [1:0] ms, logic [11:0] ps);
    logic [23:0] own, hw;
    own = {10'b0, pm, mm};
    hw  = {10'b0, ps, ms};
    return (own & hw) | (~own & d);
  endfunction

  task automatic do_frame(string tag, logic [2:0] grp, bit fall, logic [1:0] mm,
      logic [11:0] pm, logic [23:0] d, logic [1:0] ms, logic [11:0] ps);
    int len, s0;
    logic [23:0] msk, exp;
    len = chain_len(grp);
    msk = (len == 24) ? 24'hFFFFFF : ((24'h1 << len) - 24'h1);
    exp = expect_frame(d, mm, pm, ms, ps);
    modem_stat = ms; phy_stat = ps;
    cfg_fall = fall;
    wr(5'h04, {14'b0, pm[11:9], 6'b0, pm[8:6], pm[5:3], grp});
    wr(5'h08, {8'h00, d});
    edge_cnt = 0; store_hi = 0; s0 = store_cnt;
    wr(5'h00, {1'b1, 1'b0, pm[2:0], fall, mm, 24'b0});
    wait_idle();
    chk({tag, " frame"}, {8'h0, par_out & msk}, {8'h0, exp & msk});
    chk("R2 capture edges", edge_cnt, len);
    chk("R10 store cycles", store_hi, 4);
    chk("R10 store count", store_cnt, s0 + 1);
    chk("R5 idle level", {31'b0, sh_clk}, {31'b0, fall});
  endtask

  initial begin
    #1_900_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int s0, t0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state of all registers
    for (int a = 0; a < 5; a++) begin
      rd(5'(a * 4), v);
      chk("R1 reset value", v, 32'h0);
    end
    chk("R5 idle after reset", {31'b0, sh_clk}, 32'h0);

    // directed corner frames
    do_frame("R3 all groups rising", 3'b111, 1'b0, 2'b00, 12'h000, 24'hA5C381, 2'b11, 12'hFFF);
    do_frame("R2 top group only", 3'b100, 1'b1, 2'b00, 12'h000, 24'h3C96E1, 2'b00, 12'h000);
    do_frame("R2 middle group", 3'b010, 1'b1, 2'b00, 12'h000, 24'h00F00D, 2'b00, 12'h000);
    do_frame("R6 modem owns", 3'b001, 1'b1, 2'b11, 12'h000, 24'h0000FF, 2'b00, 12'h000);
    do_frame("R7 all PHYs own", 3'b111, 1'b0, 2'b00, 12'hFFF, 24'hFFFFFF, 2'b10, 12'hA5A);

    // random frames
    for (int i = 0; i < 24; i++) begin
      do_frame("R6/R7 random", 3'($urandom_range(1, 7)), 1'($urandom), 2'($urandom),
               12'($urandom), 24'($urandom), 2'($urandom), 12'($urandom));
    end

    // R9: data 0 returns the CPU value even with ownership masks set
    for (int i = 0; i < 4; i++) begin
      logic [31:0] d;
      d = $urandom;
      wr(5'h08, d);
      rd(5'h08, v);
      chk("R9 data0 readback", v, d);
    end

    // R4 / R11: self-clear, busy, held request
    cfg_fall = 1'b0;
    wr(5'h04, 32'h0000_0007);
    wr(5'h08, 32'h0012_3456);
    s0 = store_cnt;
    wr(5'h00, 32'h8000_0000);
    repeat (2) @(negedge clk);
    rd(5'h00, v);
    chk("R4 request bit cleared", {31'b0, v[31]}, 32'h0);
    chk("R11 busy during shift", {31'b0, v[0]}, 32'h1);
    wr(5'h08, 32'h00AB_CDEF);
    wr(5'h00, 32'h8000_0000);
    rd(5'h00, v);
    chk("R4 request held", {31'b0, v[31]}, 32'h1);
    wait_idle();
    chk("R4 two refreshes", store_cnt, s0 + 2);
    chk("R4 second data shown", {8'h0, par_out}, 32'h00AB_CDEF);
    rd(5'h00, v);
    chk("R11 idle busy low", {31'b0, v[0]}, 32'h0);

    // R12: no groups enabled
    wr(5'h04, 32'h0);
    edge_cnt = 0; s0 = store_cnt;
    wr(5'h00, 32'h8000_0000);
    repeat (60) @(negedge clk);
    chk("R12 no edges", edge_cnt, 0);
    chk("R12 no store", store_cnt, s0);
    rd(5'h00, v);
    chk("R12 request consumed", {v[31], v[0]}, 32'h0);

    // R8: automatic refresh rates (CLK_HZ = 4000)
    wr(5'h04, 32'h8180_0001);
    t0 = store_cnt;
    while (store_cnt < t0 + 3) @(negedge clk);
    chk("R8 period /10", last_t - prev_t, 400);
    wr(5'h04, 32'h8000_0001);
    t0 = store_cnt;
    while (store_cnt < t0 + 3) @(negedge clk);
    chk("R8 period /2", last_t - prev_t, 2000);
    wr(5'h04, 32'h4000_0001);
    wait_idle();
    s0 = store_cnt;
    repeat (2500) @(negedge clk);
    chk("R8 other source stops auto", store_cnt, s0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule